// File: doc/BRIEF.md
# Serial Divisibility-by-N Tester

This block watches a binary number arrive one bit per clock, most significant bit first. It keeps the remainder of the value received so far, taken modulo a parameter `MODULUS` (3 by default). Whenever that remainder is zero it raises a divisible flag. The remainder register is the machine's only state. The flag is decoded from that state alone, so the block behaves as a Moore machine with one state per remainder value.

Each qualified bit moves the state from `r` to `(2·r + bit) mod MODULUS`. Because `2·r + bit` is always below `2·MODULUS`, a single compare-and-subtract stage produces the next remainder, and no divider is needed. A clear input restarts the number without a full reset. After reset or a clear, the empty number counts as divisible. The input can run for any length, because only the remainder is ever stored.

Top module: `divtest_serial`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `rem_o` is 0 and `div_flag_o` is 1.
- R2: On a clock edge where `bit_vld_i` is 1 and `clear_i` is 0, `rem_o` becomes `(2·rem_o + bit_i) mod MODULUS`. Bits are taken most significant first, and the new value is visible from that edge on, which is one cycle of latency.
- R3: `div_flag_o` is 1 exactly when `rem_o` equals 0.
- R4: On an edge where both `bit_vld_i` and `clear_i` are 0, `rem_o` and `div_flag_o` keep their values, whatever `bit_i` carries.
- R5: On an edge where `clear_i` is 1, `rem_o` becomes 0 and `div_flag_o` becomes 1.
- R6: When `clear_i` and `bit_vld_i` are both 1 on the same edge, the clear wins and the bit is discarded.
- R7: `rem_o` is always strictly less than `MODULUS`.
- R8: A stream longer than the remainder register's width, with no clear in between, still yields the true remainder of the whole value after every bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clear_i | input | 1 | Restart the number; remainder returns to 0 |
| bit_vld_i | input | 1 | Qualifies `bit_i` on this cycle |
| bit_i | input | 1 | Next bit of the number, MSB first |
| div_flag_o | output | 1 | High when the value so far is a multiple of MODULUS |
| rem_o | output | max(1, ceil(log2(MODULUS))) | Current remainder of the value modulo MODULUS |

## Verification
Every 8-bit value from 0 to 63 is fed in MSB first, with a clear before each one. These runs cover every transition of the state graph, and they separate a correct `2·r + bit` update from one with the wrong shift order or a missing wrap. A 48-bit stream from a shift-register generator then runs with no clear, which shows that the remainder tracks values far wider than its register. Idle cycles with toggling data show that an unqualified bit has no effect. A clear issued together with a valid bit shows that the clear takes priority.

// File: rtl/divtest_pkg.sv
package divtest_pkg;

    // What the state register does on the next edge
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_SHIFT = 2'd2
    } act_e;

    // Clear has priority over a valid bit (R6)
    function automatic act_e pick_act(input logic clear, input logic vld);
        if (clear)
            return ACT_CLEAR;
        else if (vld)
            return ACT_SHIFT;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/divtest_step.sv
// Next remainder: (2*r + b) mod MODULUS, by one compare-and-subtract step.
// Valid because r < MODULUS gives 2*r + b < 2*MODULUS.
module divtest_step #(
    parameter int MODULUS = 3,
    parameter int REM_W   = 2
) (
    input  logic [REM_W-1:0] rem_i,
    input  logic             bit_i,
    output logic [REM_W-1:0] rem_o
);
    localparam int SUM_W = REM_W + 1;
    localparam logic [SUM_W-1:0] MOD_V = SUM_W'(MODULUS);

    logic [SUM_W-1:0] dbl;
    logic [SUM_W-1:0] diff;
    logic             wrap;

    always_comb begin
        dbl   = {rem_i, bit_i};
        wrap  = (dbl >= MOD_V);
        diff  = dbl - MOD_V;
        rem_o = wrap ? diff[REM_W-1:0] : dbl[REM_W-1:0];
    end
endmodule

// File: rtl/divtest_zero_dec.sv
// Moore output decode: flag depends on the remainder state only.
module divtest_zero_dec #(
    parameter int REM_W = 2
) (
    input  logic [REM_W-1:0] rem_i,
    output logic             zero_o
);
    always_comb zero_o = ~|rem_i;
endmodule

// File: rtl/divtest_serial.sv
module divtest_serial #(
    parameter int MODULUS = 3,
    localparam int REM_W  = (MODULUS > 2) ? $clog2(MODULUS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             bit_vld_i,
    input  logic             bit_i,
    output logic             div_flag_o,
    output logic [REM_W-1:0] rem_o
);
    import divtest_pkg::*;

    typedef struct packed {
        logic [REM_W-1:0] rem;
    } st_t;

    st_t              st_d, st_q;
    act_e             act;
    logic [REM_W-1:0] step_rem;

    divtest_step #(
        .MODULUS(MODULUS),
        .REM_W  (REM_W)
    ) u_step (
        .rem_i(st_q.rem),
        .bit_i(bit_i),
        .rem_o(step_rem)
    );

    divtest_zero_dec #(
        .REM_W(REM_W)
    ) u_dec (
        .rem_i (st_q.rem),
        .zero_o(div_flag_o)
    );

    always_comb begin
        st_d = st_q;
        act  = pick_act(clear_i, bit_vld_i);
        case (act)
            ACT_CLEAR: st_d.rem = '0;
            ACT_SHIFT: st_d.rem = step_rem;
            default:   st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rem_o = st_q.rem;

    // R1: first cycle out of reset shows remainder 0
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (rem_o == '0));

    // R2: a qualified bit applies the modular update
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (bit_vld_i && !clear_i) |=>
        (int'(rem_o) == (2 * int'($past(rem_o)) + int'($past(bit_i))) % MODULUS));

    // R3: flag from the decoder agrees with the remainder state
    p_flag_match_r3: assert property (@(posedge clk) disable iff (rst)
        div_flag_o == (rem_o == '0));

    // R4: no bit, no clear -> state holds
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!bit_vld_i && !clear_i) |=> ($stable(rem_o) && $stable(div_flag_o)));

    // R5, R6: clear forces remainder 0 even with a valid bit
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (rem_o == '0 && div_flag_o));

    // R7: remainder never reaches the modulus
    p_range_r7: assert property (@(posedge clk) disable iff (rst)
        int'(rem_o) < MODULUS);
endmodule

// File: tb/tb_divtest_serial.sv
module tb_divtest_serial;
    localparam int M = 3;
    localparam int RW = (M > 2) ? $clog2(M) : 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clear_i = 1'b0;
    logic          bit_vld_i = 1'b0;
    logic          bit_i = 1'b0;
    logic          div_flag_o;
    logic [RW-1:0] rem_o;

    typedef struct {
        int    rem;
        string req;
    } exp_t;

    exp_t q[$];
    int   tests = 0;
    int   fails = 0;
    int   model = 0;
    bit   done  = 1'b0;

    always #5 clk = ~clk;

    divtest_serial #(.MODULUS(M)) dut (
        .clk(clk), .rst(rst), .clear_i(clear_i), .bit_vld_i(bit_vld_i),
        .bit_i(bit_i), .div_flag_o(div_flag_o), .rem_o(rem_o)
    );

    task automatic check(input string req, input int act, input int expv, input string what);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Driver: set inputs at falling edge, predict, queue the expectation
    task automatic drive(input logic c, input logic v, input logic b, input string req);
        exp_t e;
        @(negedge clk);
        clear_i = c; bit_vld_i = v; bit_i = b;
        if (c) model = 0;
        else if (v) model = (2 * model + int'(b)) % M;
        e.rem = model; e.req = req;
        q.push_back(e);
    endtask

    // Monitor: just after each rising edge, compare the oldest expectation
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.req, int'(rem_o), e.rem, "remainder");
                check("R3", int'(div_flag_o), (e.rem == 0) ? 1 : 0, "flag");
                check("R7", (int'(rem_o) < M) ? 1 : 0, 1, "range");
            end
        end
    end

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [47:0] lfsr;
        repeat (3) @(posedge clk);
        #1;
        check("R1", int'(rem_o), 0, "reset remainder");
        check("R1", int'(div_flag_o), 1, "reset flag");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1", int'(rem_o), 0, "post-reset remainder");

        // R2: every value 0..63 as an 8-bit MSB-first word
        for (int val = 0; val < 64; val++) begin
            drive(1'b1, 1'b0, 1'b0, "R5");
            for (int k = 7; k >= 0; k--) begin
                logic [7:0] w;
                w = 8'(val);
                drive(1'b0, 1'b1, w[k], "R2");
            end
        end

        // R4: idle cycles with toggling data between bits
        drive(1'b1, 1'b0, 1'b0, "R5");
        drive(1'b0, 1'b1, 1'b1, "R2");
        for (int k = 0; k < 6; k++)
            drive(1'b0, 1'b0, k[0], "R4");
        drive(1'b0, 1'b1, 1'b1, "R2");
        drive(1'b0, 1'b0, 1'b1, "R4");

        // R6: clear together with a valid bit
        drive(1'b0, 1'b1, 1'b1, "R2");
        drive(1'b1, 1'b1, 1'b1, "R6");
        drive(1'b0, 1'b1, 1'b1, "R2");
        drive(1'b1, 1'b1, 1'b0, "R6");

        // R8: long stream without clear
        drive(1'b1, 1'b0, 1'b0, "R5");
        lfsr = 48'hACE1_5EED_1234;
        for (int k = 0; k < 48; k++) begin
            drive(1'b0, 1'b1, lfsr[47], "R8");
            lfsr = {lfsr[46:0], lfsr[47] ^ lfsr[46] ^ lfsr[20] ^ lfsr[19]};
        end
        drive(1'b0, 1'b0, 1'b0, "R4");

        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule